// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs the accumulator byte after two packed-BCD bytes have been added in binary. It takes that sum together with the carry and half-carry flags the addition produced. It returns a byte that again holds two decimal digits, plus the carry flag the adjust step leaves behind. The correction is applied digit by digit, starting at the low digit. Each later digit is tested on the value the earlier steps have already corrected, not on the raw sum.

The unit is purely combinational and is meant to sit next to an ALU. Its data path is presented as a stream: one transfer takes place in any cycle where `in_valid` and `out_ready` are both high. `out_valid` follows `in_valid` and `in_ready` follows `out_ready` within the same cycle, and the unit holds no storage. Back-pressure therefore passes straight through. While `out_ready` is low, the producer must keep its operand and flags steady until the transfer happens. The half-carry and overflow flags are not outputs of this unit, so the adjust operation cannot change them.

Top module: `bcd_adjust_unit`

## Requirements
- R1: When the low digit (bits 3:0) of `acc_in` is greater than 9, or `ac_in` is 1, the first step adds 06h to the byte; otherwise the first step leaves the byte unchanged.
- R2: The second step tests the high digit (bits 7:4) of the byte as it stands after the first step. It adds 60h when that digit is greater than 9, or when the carry is 1 after the first step (`cy_in` or a carry out of bit 7 from the first step).
- R3: When no step's condition holds, `acc_out` equals `acc_in` and `cy_out` equals `cy_in`; for example 92h with both flags clear gives 92h and carry 0.
- R4: A carry out of bit 7 produced by either step sets `cy_out` to 1.
- R5: When `cy_in` is 1, `cy_out` is 1 for every byte value.
- R6: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle; a transfer occurs when `in_valid` and `out_ready` are both 1.
- R7: Outputs depend only on the present inputs, with no cycle of latency and no retained state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Operand and flags are present |
| in_ready | output | 1 | Unit can accept the operand (mirrors out_ready) |
| acc_in | input | 8 | Binary sum to be adjusted |
| cy_in | input | 1 | Carry left by the preceding addition |
| ac_in | input | 1 | Half-carry left by the preceding addition |
| out_valid | output | 1 | Adjusted result is present (mirrors in_valid) |
| out_ready | input | 1 | Consumer can take the result |
| acc_out | output | 8 | Adjusted byte |
| cy_out | output | 1 | Updated carry flag |

## Verification
The bench builds the unit with its default of two digits. With that setting the whole input space is only 1024 combinations of byte, carry and half-carry, so every combination, including each case where the first step wraps the byte and forces the second step, is applied and compared against a reference model written in the bench. Random vectors and directed corner cases, such as a high digit of 9 that the low-digit fix pushes past 9, are applied on top of the sweep. The handshake pins are also toggled against each other.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGIT_MAX = 9;

  function automatic logic digit_exceeds(input logic [DIGIT_W-1:0] d);
    return d > DIGIT_W'(DIGIT_MAX);
  endfunction
endpackage

// File: rtl/bcd_digit_step.sv
module bcd_digit_step
  import bcd_adj_pkg::*;
#(
  parameter int W   = 8,
  parameter int IDX = 0
) (
  input  logic [W-1:0] v_in,
  input  logic         force_fix,
  input  logic         cy_in,
  output logic [W-1:0] v_out,
  output logic         cy_out
);
  localparam int SHIFT = IDX * DIGIT_W;

  logic [DIGIT_W-1:0] digit;
  logic               fix;
  logic [W:0]         addend;
  logic [W:0]         sum;

  always_comb begin
    digit  = v_in[SHIFT +: DIGIT_W];
    fix    = digit_exceeds(digit) || force_fix;
    addend = fix ? ({{(W-3){1'b0}}, 4'd6} << SHIFT) : '0;
    sum    = {1'b0, v_in} + addend;
    v_out  = sum[W-1:0];
    cy_out = cy_in | sum[W];
  end

  always_comb begin
    if (digit_exceeds(digit)) begin
      // R1
      fix_range_chk: assert (v_out[SHIFT +: DIGIT_W] <= 4'd5)
        else $error("corrected digit out of range");
    end
  end
endmodule

// File: rtl/bcd_step_chain.sv
module bcd_step_chain
  import bcd_adj_pkg::*;
#(
  parameter int NDIGITS = 2,
  localparam int W = NDIGITS * DIGIT_W
) (
  input  logic [W-1:0] acc_in,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic [W-1:0] acc_out,
  output logic         cy_out
);
  logic [W-1:0] val [0:NDIGITS];
  logic         cy  [0:NDIGITS];

  assign val[0] = acc_in;
  assign cy[0]  = cy_in;

  for (genvar i = 0; i < NDIGITS; i++) begin : g_step
    logic flag;
    if (i == 0) begin : g_low
      assign flag = ac_in;
    end else if (i == NDIGITS - 1) begin : g_top
      assign flag = cy[i];
    end else begin : g_mid
      assign flag = 1'b0;
    end

    bcd_digit_step #(.W(W), .IDX(i)) u_step (
      .v_in     (val[i]),
      .force_fix(flag),
      .cy_in    (cy[i]),
      .v_out    (val[i+1]),
      .cy_out   (cy[i+1])
    );
  end

  assign acc_out = val[NDIGITS];
  assign cy_out  = cy[NDIGITS];
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
#(
  parameter int NDIGITS = 2,
  localparam int W = NDIGITS * DIGIT_W
) (
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] acc_in,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] acc_out,
  output logic         cy_out
);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  bcd_step_chain #(.NDIGITS(NDIGITS)) u_chain (
    .acc_in (acc_in),
    .cy_in  (cy_in),
    .ac_in  (ac_in),
    .acc_out(acc_out),
    .cy_out (cy_out)
  );

  always_comb begin
    if (cy_in) begin
      // R5
      cy_keep_chk: assert (cy_out) else $error("carry cleared by adjust");
    end
    if (!cy_out) begin
      // R4
      no_wrap_chk: assert (acc_out >= acc_in) else $error("wrap without carry");
    end
    if (!ac_in && !cy_in && !digit_exceeds(acc_in[3:0]) && !digit_exceeds(acc_in[W-1 -: DIGIT_W])
        && NDIGITS == 2) begin
      // R3
      idle_pass_chk: assert (acc_out == acc_in && !cy_out) else $error("valid BCD altered");
    end
  end
endmodule

// File: tb/sim_bcd_adjust_unit.sv
module sim_bcd_adjust_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       in_valid, in_ready, out_valid, out_ready;
  logic [7:0] acc_in, acc_out;
  logic       cy_in, ac_in, cy_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bcd_adjust_unit u0 (
    .in_valid(in_valid), .in_ready(in_ready), .acc_in(acc_in),
    .cy_in(cy_in), .ac_in(ac_in), .out_valid(out_valid),
    .out_ready(out_ready), .acc_out(acc_out), .cy_out(cy_out)
  );

  function automatic logic [8:0] ref_adj(input logic [7:0] a, input logic c, input logic h);
    logic [8:0] s;
    logic       cy;
    s  = {1'b0, a};
    cy = c;
    if (a[3:0] > 4'd9 || h) s = s + 9'h006;
    cy = cy | s[8];
    s  = {1'b0, s[7:0]};
    if (s[7:4] > 4'd9 || cy) s = s + 9'h060;
    cy = cy | s[8];
    return {cy, s[7:0]};
  endfunction

  task automatic apply(input logic [7:0] a, input logic c, input logic h, input string tag);
    logic [8:0] exp;
    @(posedge clk);
    #1;
    acc_in = a; cy_in = c; ac_in = h;
    exp = ref_adj(a, c, h);
    @(negedge clk);
    n_chk++;
    if ({cy_out, acc_out} !== exp) begin
      n_bad++;
      $display("FAIL %s: in=%h cy=%b ac=%b got %b/%h expected %b/%h",
               tag, a, c, h, cy_out, acc_out, exp[8], exp[7:0]);
    end
  endtask

  task automatic hs(input logic v, input logic r);
    @(posedge clk);
    #1;
    in_valid = v; out_ready = r;
    @(negedge clk);
    n_chk++;
    if (out_valid !== v || in_ready !== r) begin
      n_bad++;
      $display("FAIL R6: out_valid=%b in_ready=%b expected %b %b", out_valid, in_ready, v, r);
    end
  endtask

  initial begin
    in_valid = 0; out_ready = 0; acc_in = 0; cy_in = 0; ac_in = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      n_bad++;
      $display("FAIL R6 reset: out_valid=%b in_ready=%b expected 0 0", out_valid, in_ready);
    end
    hs(1, 0); hs(0, 1); hs(1, 1); hs(0, 0);
    in_valid = 1; out_ready = 1;
    // Directed corner cases
    apply(8'h92, 0, 0, "R3 idle 92");
    apply(8'h45, 0, 0, "R3 idle 45");
    apply(8'h0C, 0, 0, "R1 low over nine");
    apply(8'h09, 0, 1, "R1 half carry");
    apply(8'h9B, 0, 0, "R2 high pushed by step one");
    apply(8'hA3, 0, 0, "R2 high over nine");
    apply(8'hFA, 0, 0, "R4 step one wraps");
    apply(8'hC0, 0, 0, "R4 step two wraps");
    apply(8'h00, 1, 0, "R5 carry held");
    apply(8'h99, 1, 1, "R5 both flags");
    // R7: exhaustive sweep, each result seen in the same cycle as its input
    for (int i = 0; i < 1024; i++)
      apply(i[7:0], i[8], i[9], "R7 sweep");
    void'($urandom(32'd1957));
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[7:0], r[8], r[9], "R1 R2 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule